// File: doc/BRIEF.md
# SECDED Memory Error Corrector with Scrub Write-Back

This block sits on the data path between a memory controller and the storage array. Each 64-bit data word is stored alongside an 8-bit check word. On the write side the block computes the check word combinationally from the outgoing data. On the read side it rebuilds the 71-position Hamming codeword and computes a 7-bit syndrome and an overall parity result. From these it delivers the corrected data one clock later, with a flag for a repaired single-bit error and a flag for an uncorrectable error.

Whenever a read needed correction, the block raises a write-back request. The request carries the read address, the corrected data and a freshly computed check word. It is held on a valid/ready handshake until the memory side takes it, so that the faulty cell is rewritten before a second upset can land in the same word. Two saturating counters record repaired and uncorrectable reads separately, which lets a failing device be spotted. A synchronous clear input empties both counters.

Top module: `ecc_scrub_unit`

## Requirements
- R1: The codeword has positions 1 to 71. Data bit k goes to the k-th position that is not a power of two, in ascending order, so bit 0 is at position 3 and bit 1 is at position 5. `wr_check[i]` for i = 0..6 is the Hamming bit at position 2^i, chosen so that the XOR of the indices of all set positions is zero. `wr_check[7]` makes the XOR of all 64 data bits and all 8 check bits equal to zero. The output is combinational.
- R2: For a stored 72-bit word {check[7:0], data[63:0]} with any one bit flipped, `out_data` equals the original data, `out_sec` is 1 and `out_ded` is 0. A flip of a check bit, including bit 7, leaves the data unchanged.
- R3: `out_valid`, `out_data`, `out_sec` and `out_ded` are registered. `out_valid` is high for exactly the cycle after each cycle in which `rd_valid` is high.
- R4: Any two flipped bits give `out_ded`=1 and `out_sec`=0, and no write-back is raised. A nonzero syndrome above 71 with bad overall parity is also reported as uncorrectable.
- R5: A read flagged `out_sec` raises `scrub_valid` in the same cycle as `out_valid`. The request carries `rd_addr`, the corrected data and the check word of R1 for that data.
- R6: While `scrub_valid` is high and `scrub_ready` is low, the address, data and check stay unchanged. A correctable read that arrives while a pending request is not being accepted is not queued: the pending request is kept and the new one is discarded.
- R7: `ce_count` rises by one for each read flagged `out_sec`, and `ue_count` rises by one for each read flagged `out_ded`. Clean reads change neither counter.
- R8: Each counter stops at its all-ones value and does not wrap.
- R9: `cnt_clear` zeroes both counters on the next clock edge and takes priority over an increment in the same cycle.
- R10: After reset, `out_valid`, `out_sec`, `out_ded` and `scrub_valid` are 0 and both counters are 0.
- R11: An unflipped word gives `out_data` equal to the stored data with both flags 0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | 64 | Data being written to memory |
| wr_check | output | 8 | Check word for `wr_data` |
| rd_valid | input | 1 | Read word present this cycle |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_data | input | 64 | Data as read from memory |
| rd_check | input | 8 | Check word as read from memory |
| out_valid | output | 1 | Corrected result valid |
| out_data | output | 64 | Corrected data |
| out_sec | output | 1 | Single error was corrected |
| out_ded | output | 1 | Uncorrectable error detected |
| scrub_valid | output | 1 | Write-back request pending |
| scrub_ready | input | 1 | Memory side accepts the write-back |
| scrub_addr | output | ADDR_W | Write-back address |
| scrub_data | output | 64 | Corrected data to write back |
| scrub_check | output | 8 | Check word for `scrub_data` |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| ce_count | output | CNT_W | Corrected-error count |
| ue_count | output | CNT_W | Uncorrectable-error count |

## Verification
A fault in the syndrome-to-position mapping shows up on the first read whose flip lands on the mis-mapped position. The wrong data, or a false uncorrectable flag, appears on `out_data` one cycle after that read, which is why every one of the 72 single flips is swept. A corrupted write-back register or a wrong hold behaviour appears on the scrub outputs in the cycle after the read, and stays visible for as long as `scrub_ready` is held low. A counter that wraps or misses a step appears at the count ports on the edge after the offending read, so counts are compared after every read. Saturation is tested by driving a counter past its top.

// File: rtl/ecc_scrub_pkg.sv
// Package: codeword geometry and helper functions shared by the
// corrector. Positions 1..71; powers of two hold Hamming bits, the
// rest hold data bits in ascending order.
package ecc_scrub_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CODE_N = DATA_W + HAM_W;

    // Scatter data and Hamming bits into codeword positions.
    function automatic logic [CODE_N:1] cw_place(input logic [DATA_W-1:0] d,
                                                 input logic [HAM_W-1:0]  h);
        logic [CODE_N:1] cw;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) == 0) begin
                for (int i = 0; i < HAM_W; i++)
                    if (p == (1 << i)) cw[p] = h[i];
            end else begin
                cw[p] = d[k];
                k++;
            end
        end
        return cw;
    endfunction

    // Gather data bits back out of a codeword.
    function automatic logic [DATA_W-1:0] cw_extract(input logic [CODE_N:1] cw);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

    // XOR of the indices of all set positions.
    function automatic logic [HAM_W-1:0] cw_syndrome(input logic [CODE_N:1] cw);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CODE_N; p++)
            if (cw[p]) s = s ^ HAM_W'(p);
        return s;
    endfunction

    // Full 8-bit check word: Hamming bits plus overall parity.
    function automatic logic [CHK_W-1:0] chk_encode(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = cw_syndrome(cw_place(d, '0));
        return {(^d) ^ (^h), h};
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Module: ecc_encoder
// Combinational check-word generator. Assumes the codeword layout of
// ecc_scrub_pkg; no state.
module ecc_encoder
    import ecc_scrub_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    // Compute check word from the data.
    always_comb check_o = chk_encode(data_i);
endmodule

// File: rtl/ecc_decoder.sv
// Module: ecc_decoder
// Combinational syndrome decode and single-bit repair. Classifies the
// word as clean, repaired or uncorrectable. Syndromes pointing beyond
// position 71 are treated as uncorrectable.
module ecc_decoder
    import ecc_scrub_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sec_o,
    output logic              ded_o
);
    logic [CODE_N:1]  cw;
    logic [CODE_N:1]  cw_fix;
    logic [HAM_W-1:0] syn;
    logic             par_bad;

    // Rebuild codeword and evaluate syndrome and overall parity.
    always_comb begin
        cw      = cw_place(data_i, check_i[HAM_W-1:0]);
        syn     = cw_syndrome(cw);
        par_bad = (^cw) ^ check_i[CHK_W-1];
    end

    // Classify and flip the pointed-at position when repairable.
    always_comb begin
        cw_fix = cw;
        sec_o  = 1'b0;
        ded_o  = 1'b0;
        if (syn == '0) begin
            sec_o = par_bad;
        end else if (!par_bad || int'(syn) > CODE_N) begin
            ded_o = 1'b1;
        end else begin
            sec_o = 1'b1;
            for (int p = 1; p <= CODE_N; p++)
                if (HAM_W'(p) == syn) cw_fix[p] = ~cw[p];
        end
        data_o = cw_extract(cw_fix);
    end
endmodule

// File: rtl/ecc_scrub_port.sv
// Module: ecc_scrub_port
// One-entry write-back request register on a valid/ready handshake.
// Assumes a new request may be loaded only when the slot is empty or
// being accepted; otherwise the new request is discarded.
module ecc_scrub_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  check_o
);
    logic take;

    // Slot free this cycle, or emptied by acceptance.
    always_comb take = load_i && (!valid_o || ready_i);

    // Hold or replace the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
            check_o <= '0;
        end else if (take) begin
            valid_o <= 1'b1;
            addr_o  <= addr_i;
            data_o  <= data_i;
            check_o <= check_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    AST_SCRUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o) && $stable(check_o))); // R6
endmodule

// File: rtl/ecc_sat_counter.sv
// Module: ecc_sat_counter
// Saturating event counter with synchronous clear; clear wins over an
// increment in the same cycle.
module ecc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = '1;

    // Count events, stick at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count_o <= '0;
        else if (clr_i)                  count_o <= '0;
        else if (inc_i && count_o != TOP) count_o <= count_o + 1'b1;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == TOP && !clr_i) |=> (count_o == TOP)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R7
endmodule

// File: rtl/ecc_scrub_unit.sv
// Module: ecc_scrub_unit (top)
// SECDED corrector for 64-bit words with 8 check bits: write-side
// encode, registered read-side correction, write-back of repaired
// words and saturating error counters. Assumes one read per cycle at
// most and a memory side that honours the valid/ready handshake.
module ecc_scrub_unit
    import ecc_scrub_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       wr_data,
    output logic [7:0]        wr_check,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [63:0]       rd_data,
    input  logic [7:0]        rd_check,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic              out_sec,
    output logic              out_ded,
    output logic              scrub_valid,
    input  logic              scrub_ready,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic [63:0]       scrub_data,
    output logic [7:0]        scrub_check,
    input  logic              cnt_clear,
    output logic [CNT_W-1:0]  ce_count,
    output logic [CNT_W-1:0]  ue_count
);
    localparam int N_CNT = 2;

    logic [DATA_W-1:0] dec_data;
    logic              dec_sec;
    logic              dec_ded;
    logic [CHK_W-1:0]  fix_check;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    ecc_encoder u_wr_enc (.data_i(wr_data), .check_o(wr_check));

    ecc_decoder u_dec (
        .data_i (rd_data),
        .check_i(rd_check),
        .data_o (dec_data),
        .sec_o  (dec_sec),
        .ded_o  (dec_ded)
    );

    ecc_encoder u_fix_enc (.data_i(dec_data), .check_o(fix_check));

    // Register the corrected result one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sec   <= 1'b0;
            out_ded   <= 1'b0;
        end else begin
            out_valid <= rd_valid;
            out_data  <= dec_data;
            out_sec   <= rd_valid && dec_sec;
            out_ded   <= rd_valid && dec_ded;
        end
    end

    ecc_scrub_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_scrub (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_valid && dec_sec),
        .addr_i (rd_addr),
        .data_i (dec_data),
        .check_i(fix_check),
        .valid_o(scrub_valid),
        .ready_i(scrub_ready),
        .addr_o (scrub_addr),
        .data_o (scrub_data),
        .check_o(scrub_check)
    );

    // Event strobes: index 0 repaired, index 1 uncorrectable.
    always_comb cnt_inc = {rd_valid && dec_ded, rd_valid && dec_sec};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        ecc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (cnt_clear),
            .inc_i  (cnt_inc[g]),
            .count_o(cnt_val[g])
        );
    end

    assign ce_count = cnt_val[0];
    assign ue_count = cnt_val[1];

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sec && out_ded)); // R4
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid); // R3
    AST_SCRUB_ONLY_ON_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scrub_valid) |-> (out_sec && !out_ded)); // R5
endmodule

// File: tb/sim_ecc_scrub_unit.sv
module sim_ecc_scrub_unit;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int NONE = 99;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_check;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data = '0;
    logic [7:0]    rd_check = '0;
    logic          out_valid, out_sec, out_ded;
    logic [63:0]   out_data;
    logic          scrub_valid;
    logic          scrub_ready = 1'b1;
    logic [AW-1:0] scrub_addr;
    logic [63:0]   scrub_data;
    logic [7:0]    scrub_check;
    logic          cnt_clear = 1'b0;
    logic [CW-1:0] ce_count, ue_count;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_ce  = 0;
    int exp_ue  = 0;

    always #2 clk = ~clk;

    ecc_scrub_unit #(.ADDR_W(AW), .CNT_W(CW)) u0 (.*);

    // Stimulus table: data, first flip, second flip (NONE = no flip).
    localparam int NT = 12;
    localparam logic [63:0] TV_D [NT] = '{
        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0123_4567, 64'h8000_0000_0000_0001,
        64'hA5A5_5A5A_F0F0_0F0F, 64'h1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'h5555_5555_5555_5555, 64'hCAFE_F00D_1234_5678, 64'h7FFF_FFFF_FFFF_FFFE, 64'h0F0F_0F0F_0F0F_0F0F};
    localparam int TV_F1 [NT] = '{NONE, NONE, 0, 63, 64, 71, 30, 0, 70, 64, 71, 12};
    localparam int TV_F2 [NT] = '{NONE, NONE, NONE, NONE, NONE, NONE, 31, 63, 71, 65, 3, 40};

    // Model of the check word from R1.
    function automatic logic [7:0] tb_enc(input logic [63:0] d);
        logic [6:0] h = '0;
        int k = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) h = h ^ 7'(p);
                k++;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one read with optional flips, optional clear in the same cycle.
    task automatic do_read(input logic [63:0] d, input int f1, input int f2,
                           input logic [AW-1:0] a, input logic clr);
        logic [71:0] w;
        w = {tb_enc(d), d};
        if (f1 != NONE) w[f1] = ~w[f1];
        if (f2 != NONE) w[f2] = ~w[f2];
        @(negedge clk);
        rd_valid  = 1'b1;
        rd_addr   = a;
        rd_data   = w[63:0];
        rd_check  = w[71:64];
        cnt_clear = clr;
        @(negedge clk);
        rd_valid  = 1'b0;
        cnt_clear = 1'b0;
    endtask

    // Check the result of the read just done (scrub_ready assumed high).
    task automatic check_read(input string req, input logic [63:0] d,
                              input logic e_sec, input logic e_ded, input logic [AW-1:0] a);
        chk(req, "out_valid", 64'(out_valid), 64'd1);
        chk(req, "out_sec", 64'(out_sec), 64'(e_sec));
        chk(req, "out_ded", 64'(out_ded), 64'(e_ded));
        if (!e_ded) chk(req, "out_data", out_data, d);
        chk(req, "scrub_valid", 64'(scrub_valid), 64'(e_sec));
        if (e_sec) begin
            chk(req, "scrub_addr", 64'(scrub_addr), 64'(a));
            chk(req, "scrub_data", scrub_data, d);
            chk(req, "scrub_check", 64'(scrub_check), 64'(tb_enc(d)));
        end
        if (e_sec && exp_ce < 255) exp_ce++;
        if (e_ded && exp_ue < 255) exp_ue++;
        chk(req, "ce_count", 64'(ce_count), 64'(exp_ce));
        chk(req, "ue_count", 64'(ue_count), 64'(exp_ue));
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] pat;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "out_valid", 64'(out_valid), 64'd0);
        chk("R10", "scrub_valid", 64'(scrub_valid), 64'd0);
        chk("R10", "ce_count", 64'(ce_count), 64'd0);
        chk("R10", "ue_count", 64'(ue_count), 64'd0);
        chk("R10", "flags", 64'({out_sec, out_ded}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: write-side encoder against the model
        for (int i = 0; i < NT; i++) begin
            wr_data = TV_D[i];
            #1;
            chk("R1", "wr_check", 64'(wr_check), 64'(tb_enc(TV_D[i])));
        end
        wr_data = 64'h1;
        #1 chk("R1", "wr_check bit0", 64'(wr_check), 64'h83);

        // Table walk: R2, R4, R5, R11
        for (int i = 0; i < NT; i++) begin
            logic es, ed;
            es = (TV_F1[i] != NONE) && (TV_F2[i] == NONE);
            ed = (TV_F2[i] != NONE);
            do_read(TV_D[i], TV_F1[i], TV_F2[i], AW'(i + 16'h100), 1'b0);
            check_read(ed ? "R4" : (es ? "R2" : "R11"), TV_D[i], es, ed, AW'(i + 16'h100));
        end

        // R3: out_valid drops the cycle after
        @(negedge clk);
        chk("R3", "out_valid idle", 64'(out_valid), 64'd0);

        // R2/R5/R7: sweep every single flip
        pat = 64'h3C96_E1A7_5B08_F24D;
        for (int b = 0; b < 72; b++) begin
            do_read(pat ^ 64'(b), b, NONE, AW'(b), 1'b0);
            check_read("R2", pat ^ 64'(b), 1'b1, 1'b0, AW'(b));
        end

        // R4/R7: sample of double flips
        for (int b = 0; b < 72; b += 3) begin
            int c;
            c = (b * 7 + 13) % 72;
            if (c == b) c = (b + 1) % 72;
            do_read(~pat, b, c, AW'(b), 1'b0);
            check_read("R4", ~pat, 1'b0, 1'b1, AW'(b));
        end

        // R4: triple flip of Hamming bits at 1,8,64 gives syndrome 73, bad parity
        begin
            logic [71:0] w;
            w = {tb_enc(pat), pat};
            w[64] = ~w[64]; w[67] = ~w[67]; w[70] = ~w[70];
            @(negedge clk);
            rd_valid = 1'b1; rd_data = w[63:0]; rd_check = w[71:64];
            @(negedge clk);
            rd_valid = 1'b0;
            check_read("R4", pat, 1'b0, 1'b1, '0);
        end

        // R6: hold under backpressure, second request discarded
        scrub_ready = 1'b0;
        do_read(64'hAAAA_0000_1111_2222, 5, NONE, 16'h0A0A, 1'b0);
        chk("R6", "scrub_valid", 64'(scrub_valid), 64'd1);
        chk("R6", "scrub_addr", 64'(scrub_addr), 64'h0A0A);
        do_read(64'hBBBB_3333_4444_5555, 9, NONE, 16'h0B0B, 1'b0);
        chk("R6", "out_sec second", 64'(out_sec), 64'd1);
        chk("R6", "scrub_addr kept", 64'(scrub_addr), 64'h0A0A);
        chk("R6", "scrub_data kept", scrub_data, 64'hAAAA_0000_1111_2222);
        repeat (3) @(negedge clk);
        chk("R6", "scrub_valid held", 64'(scrub_valid), 64'd1);
        chk("R6", "scrub_check kept", 64'(scrub_check), 64'(tb_enc(64'hAAAA_0000_1111_2222)));
        scrub_ready = 1'b1;
        @(negedge clk);
        chk("R6", "nothing queued", 64'(scrub_valid), 64'd0);
        exp_ce += 2;
        chk("R7", "ce after two", 64'(ce_count), 64'(exp_ce));

        // R9: clear alone, then clear with an increment
        @(negedge clk); cnt_clear = 1'b1;
        @(negedge clk); cnt_clear = 1'b0;
        chk("R9", "ce cleared", 64'(ce_count), 64'd0);
        chk("R9", "ue cleared", 64'(ue_count), 64'd0);
        do_read(pat, 7, NONE, '0, 1'b1);
        chk("R9", "clear wins", 64'(ce_count), 64'd0);
        exp_ce = 0; exp_ue = 0;

        // R7: clean read leaves counters
        do_read(pat, NONE, NONE, '0, 1'b0);
        check_read("R7", pat, 1'b0, 1'b0, '0);

        // R8: saturation
        for (int i = 0; i < 260; i++) do_read(pat, 2, NONE, '0, 1'b0);
        chk("R8", "ce saturated", 64'(ce_count), 64'(CMAX));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule